// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital control side of a multi-channel analog-to-digital converter. Software programs a single 16-bit control and status word over a plain register bus. That word holds six things: the start request, the mode, the highest channel to use, the conversion clock ratio, the interrupt enable and the completion flag. The block then drives an external converter. For each conversion it sends a one-cycle start strobe that carries a channel number and a conversion length. It waits for the converter's one-cycle done strobe before moving on.

There are three sequencing modes. Single mode converts just the named channel once. Multi mode walks channels 0 up to the named channel once, in ascending order. Scan mode repeats that walk until software drops the start bit. The completion flag is raised at the end of each conversion in single mode and at the end of each walk in the other two modes. An interrupt request follows the flag when the interrupt is enabled. Software can lower the flag only by first reading it as 1 and then writing 0. A standby input puts the register back to its reset contents.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x0080. Fields: bit 15 flag, bit 14 interrupt enable, bit 13 start, bits 7:6 clock ratio, bits 5:4 mode, bits 2:0 channel.
- R2: Bits 12 to 8 and bit 3 always read 0, whatever value was written to them.
- R3: Writing 1 to bit 15 never sets the flag.
- R4: A write of 0 to bit 15 clears the flag only if a bus read returned the flag as 1 beforehand. Without such a read the flag stays 1.
- R5: Mode 0 (single) makes exactly one conversion on the channel given in bits 2:0. It then sets the flag and clears the start bit.
- R6: Mode 1 (multi) converts channels 0 up to the channel field value, once each in ascending order. It then sets the flag and clears the start bit.
- R7: While a start strobe is high, `conv_len` equals 8 shifted left by the clock ratio field: 8, 16, 32 or 64 cycles.
- R8: `irq` is high exactly when both the flag and the interrupt enable are 1.
- R9: Each start strobe lasts one cycle. No new strobe is sent until the done strobe for the previous conversion has arrived.
- R10: Mode 2 or 3 (scan) repeats the channel walk, setting the flag after every walk. The start bit stays 1.
- R11: If software clears the start bit mid-sequence, the conversion in progress is dropped. No further strobes are sent and the flag is not set.
- R12: One cycle of `standby` returns the register to 0x0080 and stops any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Reloads the register's reset contents |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register contents |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 3 | Channel for the strobed conversion |
| conv_len | output | 7 | Conversion length in prescaler cycles |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a sequence that is cut short. The start bit has to drop while a conversion is still outstanding, and the late done strobe must then be ignored. The bench gets there by polling its converter model's strobe count. Once the first strobe of a long multi walk has gone out, it writes the start bit low before the model's fixed latency has expired. In a second case it drops the start bit during a scan that has already completed one walk. It also brings about the armed-clear ordering by performing a write of 0 with no prior read, and then a read followed by the same write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W    = 16;
  localparam int CH_W     = 3;
  localparam int CKS_W    = 2;
  localparam int MODE_W   = 2;
  localparam int FLAG_BIT = 15;
  localparam int IE_BIT   = 14;
  localparam int ST_BIT   = 13;
  localparam int CKS_LSB  = 6;
  localparam int MODE_LSB = 4;
  localparam int CH_LSB   = 0;
  localparam logic [CSR_W-1:0] CSR_RESET = 16'h0080;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             ie;
    logic             st;
    logic [CKS_W-1:0] cks;
    logic [MODE_W-1:0] mode;
    logic [CH_W-1:0]  ch;
  } csr_cfg_t;
endpackage

// File: rtl/adc_csr.sv
module adc_csr
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CSR_W-1:0] bus_wdata,
  input  logic             pass_end,
  input  logic             st_clr,
  output csr_cfg_t         cfg,
  output logic             flag,
  output logic [CSR_W-1:0] rdata
);
  localparam csr_cfg_t CFG_RESET = '{
    ie:   CSR_RESET[IE_BIT],
    st:   CSR_RESET[ST_BIT],
    cks:  CSR_RESET[CKS_LSB +: CKS_W],
    mode: CSR_RESET[MODE_LSB +: MODE_W],
    ch:   CSR_RESET[CH_LSB +: CH_W]
  };

  csr_cfg_t cfg_q;
  logic     flag_q;
  logic     armed_q;
  logic     clr_req;

  // a write of 0 to the flag after an armed read
  assign clr_req = bus_wr && !bus_wdata[FLAG_BIT] && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      flag_q  <= CSR_RESET[FLAG_BIT];
      armed_q <= 1'b0;
    end else if (standby) begin
      cfg_q   <= CFG_RESET;
      flag_q  <= CSR_RESET[FLAG_BIT];
      armed_q <= 1'b0;
    end else begin
      if (bus_wr) begin
        cfg_q.ie   <= bus_wdata[IE_BIT];
        cfg_q.st   <= bus_wdata[ST_BIT];
        cfg_q.cks  <= bus_wdata[CKS_LSB +: CKS_W];
        cfg_q.mode <= bus_wdata[MODE_LSB +: MODE_W];
        cfg_q.ch   <= bus_wdata[CH_LSB +: CH_W];
      end else if (st_clr) begin
        cfg_q.st <= 1'b0;
      end
      // a completing pass wins over a simultaneous clear
      if (pass_end) begin
        flag_q <= 1'b1;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
      if (clr_req && !pass_end) begin
        armed_q <= 1'b0;
      end else if (bus_rd && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign cfg  = cfg_q;
  assign flag = flag_q;

  always_comb begin
    rdata = '0;
    rdata[FLAG_BIT]                = flag_q;
    rdata[IE_BIT]                  = cfg_q.ie;
    rdata[ST_BIT]                  = cfg_q.st;
    rdata[CKS_LSB +: CKS_W]        = cfg_q.cks;
    rdata[MODE_LSB +: MODE_W]      = cfg_q.mode;
    rdata[CH_LSB +: CH_W]          = cfg_q.ch;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st,
  input  logic [MODE_W-1:0] mode,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              pass_end,
  output logic              st_clr
);
  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            is_single, is_scan, last_ch;

  assign is_single = (mode == 2'd0);
  assign is_scan   = mode[1];
  assign last_ch   = is_single || (cur_q == ch_sel);

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    pass_end = 1'b0;
    st_clr   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (st) begin
          state_d = SEQ_ISSUE;
          cur_d   = is_single ? ch_sel : '0;
        end
      end
      SEQ_ISSUE: begin
        state_d = st ? SEQ_WAIT : SEQ_IDLE;
      end
      SEQ_WAIT: begin
        if (!st) begin
          state_d = SEQ_IDLE;
        end else if (conv_done) begin
          if (last_ch) begin
            pass_end = 1'b1;
            if (is_scan) begin
              cur_d   = '0;
              state_d = SEQ_ISSUE;
            end else begin
              st_clr  = 1'b1;
              state_d = SEQ_IDLE;
            end
          end else begin
            cur_d   = cur_q + 1'b1;
            state_d = SEQ_ISSUE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  assign conv_start = (state_q == SEQ_ISSUE) && st;
  assign conv_chan  = cur_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int LEN_BASE_LOG2 = 3,
  localparam int LEN_W = LEN_BASE_LOG2 + (1 << CKS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic [LEN_W-1:0] conv_len,
  input  logic             conv_done,
  output logic             irq
);
  csr_cfg_t cfg;
  logic     flag, pass_end, st_clr;

  adc_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .pass_end  (pass_end),
    .st_clr    (st_clr),
    .cfg       (cfg),
    .flag      (flag),
    .rdata     (bus_rdata)
  );

  adc_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (cfg.st),
    .mode       (cfg.mode),
    .ch_sel     (cfg.ch),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .pass_end   (pass_end),
    .st_clr     (st_clr)
  );

  // length doubles with each step of the clock ratio field
  assign conv_len = LEN_W'(1 << (LEN_BASE_LOG2 + int'(cfg.cks)));
  assign irq      = flag && cfg.ie;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        standby,
  input logic [15:0] bus_rdata,
  input logic        conv_start,
  input logic        conv_done,
  input logic        irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[12:8] == 5'd0) && !bus_rdata[3]);                       // R2
  AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[15]) |-> $past(conv_done));                         // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (bus_rdata[15] && bus_rdata[14]));                           // R8
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);                                        // R9
  AST_STANDBY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (bus_rdata == 16'h0080));                               // R12
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .standby    (standby),
  .bus_rdata  (bus_rdata),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .irq        (irq)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int LAT = 5;
  localparam int NVEC = 5;
  // {mode[11:10], ch[9:7], cks[6:5], ie[4], starts[3:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 3'd5, 2'd0, 1'b1, 4'd1},
    {2'd1, 3'd3, 2'd1, 1'b0, 4'd4},
    {2'd1, 3'd0, 2'd3, 1'b1, 4'd1},
    {2'd0, 3'd7, 2'd2, 1'b0, 4'd1},
    {2'd1, 3'd7, 2'd0, 1'b1, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic [6:0]  conv_len;
  logic        conv_done = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_len(conv_len),
    .conv_done(conv_done), .irq(irq)
  );

  // converter model: fixed-latency done strobe, logs every start
  int         nstarts = 0;
  int         dcnt = 0;
  int         overlap = 0;
  int         longpulse = 0;
  logic       prev_start = 1'b0;
  logic [2:0] chlog [256];
  logic [6:0] last_len = '0;
  always @(posedge clk) begin
    conv_done  <= 1'b0;
    prev_start <= conv_start;
    if (dcnt > 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) conv_done <= 1'b1;
    end
    if (conv_start) begin
      if (dcnt > 0) overlap <= overlap + 1;
      if (prev_start) longpulse <= longpulse + 1;
      chlog[nstarts % 256] <= conv_chan;
      last_len <= conv_len;
      nstarts  <= nstarts + 1;
      dcnt     <= LAT;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_flag(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bus_rdata[15]) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit          seen;
    int          base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rdata == 16'h0080, "R1 reset value", bus_rdata, 16'h0080);
    chk(!irq && !conv_start, "R1 reset outputs", {irq, conv_start}, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  md;
      logic [2:0]  ch;
      logic [1:0]  ck;
      logic        ie;
      int          n;
      logic [15:0] w;
      md = VEC[v][11:10]; ch = VEC[v][9:7]; ck = VEC[v][6:5];
      ie = VEC[v][4];     n  = int'(VEC[v][3:0]);
      w  = {1'b0, ie, 1'b1, 5'd0, ck, md, 1'b0, ch};
      base = nstarts;
      bus_write(w);
      wait_flag(seen);
      chk(seen, (md == 0) ? "R5 flag set" : "R6 flag set", seen, 1);
      repeat (3) @(negedge clk);
      chk(nstarts - base == n, (md == 0) ? "R5 count" : "R6 count", nstarts - base, n);
      for (int i = 0; i < n; i++) begin
        logic [2:0] e;
        e = (md == 0) ? ch : 3'(i);
        chk(chlog[(base + i) % 256] == e, (md == 0) ? "R5 channel" : "R6 order",
            chlog[(base + i) % 256], e);
      end
      chk(bus_rdata[13] == 1'b0, "R5/R6 start self-clear", bus_rdata[13], 0);
      chk(irq == ie, "R8 irq", irq, ie);
      chk(last_len == 7'(8 << ck), "R7 length", last_len, 8 << ck);
      bus_read(rd);
      bus_write(w & 16'h5FFF);
      chk(bus_rdata[15] == 1'b0 && !irq, "R4 armed clear", bus_rdata[15], 0);
    end

    // R2 reserved bits
    bus_write(16'h5F08);
    chk(bus_rdata == 16'h4000, "R2 reserved", bus_rdata, 16'h4000);
    // R3 writing 1 to the flag
    bus_write(16'h8000);
    chk(bus_rdata == 16'h0000, "R3 flag write 1", bus_rdata, 16'h0000);

    // R4 clear without read
    bus_write(16'h2002);
    wait_flag(seen);
    bus_write(16'h0002);
    chk(bus_rdata[15] == 1'b1, "R4 clear without read", bus_rdata[15], 1);
    bus_read(rd);
    chk(rd[15] == 1'b1, "R4 read flag", rd[15], 1);
    bus_write(16'h0002);
    chk(bus_rdata[15] == 1'b0, "R4 clear after read", bus_rdata[15], 0);

    // R10 scan mode, channels 0..1
    base = nstarts;
    bus_write(16'h6021);
    wait_flag(seen);
    bus_read(rd);
    bus_write(16'h6021);
    wait_flag(seen);
    chk(seen, "R10 second pass flag", seen, 1);
    chk(bus_rdata[13] == 1'b1, "R10 start kept", bus_rdata[13], 1);
    chk(nstarts - base >= 4, "R10 repeated passes", nstarts - base, 4);
    chk(chlog[(base + 2) % 256] == 3'd0 && chlog[(base + 3) % 256] == 3'd1,
        "R10 pass order", {chlog[(base + 2) % 256], chlog[(base + 3) % 256]}, 1);
    // R11 stop the scan
    bus_write(16'h4021);
    base = nstarts;
    repeat (30) @(negedge clk);
    chk(nstarts == base, "R11 scan stop", nstarts - base, 0);
    bus_read(rd);
    bus_write(16'h0021);

    // R11 abandon a multi walk after its first strobe
    base = nstarts;
    bus_write(16'h20D7);
    for (int i = 0; i < 100 && nstarts == base; i++) @(negedge clk);
    bus_write(16'h00D7);
    repeat (30) @(negedge clk);
    chk(nstarts - base == 1, "R11 abandon count", nstarts - base, 1);
    chk(bus_rdata[15] == 1'b0, "R11 no flag", bus_rdata[15], 0);

    // R9 strobe shape across the whole run
    chk(longpulse == 0, "R9 one-cycle strobe", longpulse, 0);
    chk(overlap == 0, "R9 no strobe while busy", overlap, 0);

    // R12 standby reload mid-sequence
    bus_write(16'h60E5);
    repeat (2) @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    chk(bus_rdata == 16'h0080, "R12 standby", bus_rdata, 16'h0080);
    base = nstarts;
    repeat (20) @(negedge clk);
    chk(nstarts == base, "R12 sequence stopped", nstarts - base, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule